// File: doc/BRIEF.md
# Guarded Battery-Domain Register Bank

This block holds a small bank of general-purpose data words that live in the battery-powered domain of a chip. Software stores state in it that must survive a main-supply loss. The words can be read at any time. A write is refused unless an enable sequence has been completed. First the power-interface clock enable must be high. Then the domain unlock bit must go from low to high while that clock enable is already high. The real-time-clock enable must also be high in the cycle of the write. If any of these conditions is withdrawn, the bank locks again.

A tamper input erases every word at once. It acts asynchronously: the bank reads zero for as long as the tamper input is high. If a tamper event and a bus write fall in the same cycle, the erase takes precedence. Bus reads are combinational, so the read data follows the address in the same cycle.

Top module: `bkup_vault`

## Requirements
- R1: After reset, every word reads 0 and the bank is locked. No write changes any word until the unlock sequence of R2 has completed.
- R2: The bank unlocks at the clock edge where `ifClkEn` is 1 and `protDis` is 1 after having been 0 at the previous edge. Reset counts as `protDis` having been 1, so a `protDis` held high through reset, or set while `ifClkEn` is 0, does not unlock the bank until it is cleared and set again.
- R3: A write is taken at a clock edge only if the bank is unlocked, `wrEn` is 1 and `rtcClkEn` is 1 at that edge. With `rtcClkEn` at 0 the write is dropped.
- R4: The bank has 20 words of 32 bits at addresses 0 to 19. A write that is taken is returned by a read of the same address from the next cycle on.
- R5: `rdData` shows the word at `addr` combinationally, whether or not the bank is unlocked.
- R6: While `tamper` is 1, all 20 words are zero, and they stay zero after `tamper` falls. A write at an edge where `tamper` is 1 is discarded.
- R7: A write to an address of 20 or above changes no word, and a read of such an address returns 0.
- R8: If `protDis` or `ifClkEn` is 0 at an edge, the bank is locked from that edge on. Every stored word keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bank clock |
| rstN | input | 1 | Asynchronous active-low domain reset |
| ifClkEn | input | 1 | Power-interface clock enable |
| protDis | input | 1 | Domain unlock bit |
| rtcClkEn | input | 1 | Real-time-clock enable |
| tamper | input | 1 | Asynchronous erase, active high |
| addr | input | 5 | Word address |
| wrEn | input | 1 | Write strobe |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr` |

## Verification
Two functions can act in the same cycle: the tamper erase and an accepted bus write. The bench provokes this by unlocking the bank and then raising `tamper` during a cycle that also carries a write, with `rtcClkEn` high, to a valid address. Once `tamper` falls, the address is read back. Zero is the only correct result; the written value means the write won.

A second overlap comes from the lock itself. The cycle that drops `protDis` still carries a write. The following cycle must refuse a write while the earlier contents stay readable.

// File: rtl/bkup_vault_pkg.sv
package bkup_vault_pkg;
  localparam int BKV_DATA_W = 32;
  localparam int BKV_ADDR_W = 5;

  typedef struct packed {
    logic                  wrStb;
    logic [BKV_ADDR_W-1:0] wrIdx;
  } bkv_strobe_t;
endpackage

// File: rtl/bkup_vault_ctrl.sv
module bkup_vault_ctrl
  import bkup_vault_pkg::*;
#(
  parameter int NUM_REGS = 20
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  ifClkEn,
  input  logic                  protDis,
  input  logic                  rtcClkEn,
  input  logic [BKV_ADDR_W-1:0] addr,
  input  logic                  wrEn,
  output logic                  gateOpen,
  output bkv_strobe_t           strobes
);
  localparam logic [BKV_ADDR_W-1:0] LAST_IDX = BKV_ADDR_W'(NUM_REGS - 1);

  logic protDisQ;
  logic openNext;
  logic addrValid;

  // Unlock only on a low-to-high step of protDis while the interface clock runs.
  assign openNext  = ifClkEn && protDis && (gateOpen || !protDisQ);
  assign addrValid = (addr <= LAST_IDX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      protDisQ <= 1'b1;
      gateOpen <= 1'b0;
    end else begin
      protDisQ <= protDis;
      gateOpen <= openNext;
    end
  end

  always_comb begin
    strobes.wrStb = wrEn && gateOpen && rtcClkEn && addrValid;
    strobes.wrIdx = addr;
  end
endmodule

// File: rtl/bkup_vault_dp.sv
module bkup_vault_dp
  import bkup_vault_pkg::*;
#(
  parameter int NUM_REGS = 20
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  tamper,
  input  bkv_strobe_t           strobes,
  input  logic [BKV_DATA_W-1:0] wrData,
  input  logic [BKV_ADDR_W-1:0] addr,
  output logic [BKV_DATA_W-1:0] rdData
);
  logic [BKV_DATA_W-1:0] bank [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_word
    logic hit;
    assign hit = strobes.wrStb && (strobes.wrIdx == BKV_ADDR_W'(g));
    always_ff @(posedge clk or negedge rstN or posedge tamper) begin
      if (!rstN) begin
        bank[g] <= '0;
      end else if (tamper) begin
        bank[g] <= '0;
      end else if (hit) begin
        bank[g] <= wrData;
      end
    end
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (addr == BKV_ADDR_W'(i)) rdData = bank[i];
    end
  end
endmodule

// File: rtl/bkup_vault.sv
module bkup_vault
  import bkup_vault_pkg::*;
#(
  parameter int NUM_REGS = 20
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  ifClkEn,
  input  logic                  protDis,
  input  logic                  rtcClkEn,
  input  logic                  tamper,
  input  logic [BKV_ADDR_W-1:0] addr,
  input  logic                  wrEn,
  input  logic [BKV_DATA_W-1:0] wrData,
  output logic [BKV_DATA_W-1:0] rdData
);
  logic        gateOpen;
  bkv_strobe_t strobes;

  bkup_vault_ctrl #(.NUM_REGS(NUM_REGS)) u_ctrl (
    .clk(clk), .rstN(rstN), .ifClkEn(ifClkEn), .protDis(protDis),
    .rtcClkEn(rtcClkEn), .addr(addr), .wrEn(wrEn),
    .gateOpen(gateOpen), .strobes(strobes)
  );

  bkup_vault_dp #(.NUM_REGS(NUM_REGS)) u_dp (
    .clk(clk), .rstN(rstN), .tamper(tamper), .strobes(strobes),
    .wrData(wrData), .addr(addr), .rdData(rdData)
  );
endmodule

// File: rtl/bkup_vault_chk.sv
module bkup_vault_chk
  import bkup_vault_pkg::*;
#(
  parameter int NUM_REGS = 20
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  ifClkEn,
  input logic                  protDis,
  input logic                  rtcClkEn,
  input logic                  tamper,
  input logic [BKV_ADDR_W-1:0] addr,
  input logic                  wrEn,
  input logic [BKV_DATA_W-1:0] wrData,
  input logic [BKV_DATA_W-1:0] rdData,
  input logic                  gateOpen
);
  logic accepted;
  assign accepted = wrEn && gateOpen && rtcClkEn && !tamper && (int'(addr) < NUM_REGS);

  a_r6_tamper_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    tamper |-> (rdData == '0));

  a_r7_oob_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    (int'(addr) >= NUM_REGS) |-> (rdData == '0));

  a_r8_relock_next: assert property (@(posedge clk) disable iff (!rstN)
    (!protDis || !ifClkEn) |=> !gateOpen);

  a_r2_open_needs_seq: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gateOpen) |-> ($past(ifClkEn) && $past(protDis)));

  a_r4_write_visible: assert property (@(posedge clk) disable iff (!rstN)
    accepted |=> (tamper || addr != $past(addr) || rdData == $past(wrData)));

  a_r1_locked_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!gateOpen && !tamper) |=> (tamper || addr != $past(addr) || $stable(rdData)));
endmodule

bind bkup_vault bkup_vault_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk(clk), .rstN(rstN), .ifClkEn(ifClkEn), .protDis(protDis),
  .rtcClkEn(rtcClkEn), .tamper(tamper), .addr(addr), .wrEn(wrEn),
  .wrData(wrData), .rdData(rdData), .gateOpen(gateOpen)
);

// File: tb/bkup_vault_tb.sv
module bkup_vault_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ifClkEn = 1'b0, protDis = 1'b0, rtcClkEn = 1'b0, tamper = 1'b0;
  logic [4:0]  addr = '0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;

  int checks = 0, errors = 0;
  string tag = "R1";
  bit done = 0;

  // reference state
  logic [31:0] model [20];
  bit mOpen = 0, mPrevProt = 1;

  always #2.5 clk = ~clk;

  bkup_vault u_dut (.clk(clk), .rstN(rstN), .ifClkEn(ifClkEn), .protDis(protDis),
    .rtcClkEn(rtcClkEn), .tamper(tamper), .addr(addr), .wrEn(wrEn),
    .wrData(wrData), .rdData(rdData));

  initial for (int i = 0; i < 20; i++) model[i] = '0;

  always @(posedge tamper) for (int i = 0; i < 20; i++) model[i] = '0;

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 20; i++) model[i] = '0;
      mOpen = 0; mPrevProt = 1;
    end else begin
      if (tamper) for (int i = 0; i < 20; i++) model[i] = '0;
      else if (wrEn && mOpen && rtcClkEn && addr < 20) model[addr] = wrData;
      mOpen = ifClkEn && protDis && (mOpen || !mPrevProt);
      mPrevProt = protDis;
    end
  end

  function automatic logic [31:0] expRead();
    return (addr < 20) ? model[addr] : 32'h0;
  endfunction

  task automatic check(string t, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: addr=%0d actual=%h expected=%h", t, addr, act, exp);
    end
  endtask

  // compare on every cycle, half a period away from the sampling edge
  always @(negedge clk) if (rstN && !done) check(tag, rdData, expRead());

  task automatic cyc(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    addr = a; wrData = d; wrEn = 1; cyc();
    wrEn = 0; cyc();
  endtask

  task automatic unlock();
    protDis = 0; cyc();
    ifClkEn = 1; cyc();
    protDis = 1; cyc();
  endtask

  initial begin
    fork
      begin
        // R1: reset state and locked bank
        cyc(3); rstN = 1; cyc();
        tag = "R1";
        for (int a = 0; a < 32; a++) begin addr = 5'(a); #0.5 check("R1 reset", rdData, 32'h0); cyc(); end
        rtcClkEn = 1;
        wr(5'd3, 32'hDEAD_0003);
        addr = 5'd3; #0.5 check("R1 locked", rdData, 32'h0); cyc();

        // R2: unlock bit set before clock enable does not open
        tag = "R2";
        protDis = 1; cyc(); ifClkEn = 1; cyc();
        wr(5'd4, 32'h1111_0004);
        addr = 5'd4; #0.5 check("R2 wrong order", rdData, 32'h0); cyc();
        protDis = 0; cyc(); protDis = 1; cyc();
        wr(5'd4, 32'h2222_0004);
        addr = 5'd4; #0.5 check("R2 unlocked", rdData, 32'h2222_0004); cyc();

        // R3: clock enable gates writes
        tag = "R3";
        rtcClkEn = 0; wr(5'd4, 32'h3333_0004);
        addr = 5'd4; #0.5 check("R3 rtc off", rdData, 32'h2222_0004); cyc();
        rtcClkEn = 1;

        // R4 / R5: fill and read back
        tag = "R4";
        for (int a = 0; a < 20; a++) wr(5'(a), 32'hA5A5_0000 | 32'(a * 7));
        for (int a = 0; a < 20; a++) begin addr = 5'(a); #0.5 check("R4 readback", rdData, 32'hA5A5_0000 | 32'(a * 7)); cyc(); end
        addr = 5'd9; wrData = 32'h0BAD_F00D; wrEn = 1; cyc(); wrEn = 0;
        #0.5 check("R4 next cycle", rdData, 32'h0BAD_F00D); cyc();

        // R7: out-of-range
        tag = "R7";
        wr(5'd20, 32'hFFFF_FFFF); wr(5'd31, 32'hFFFF_FFFF);
        addr = 5'd20; #0.5 check("R7 read 20", rdData, 32'h0); cyc();
        addr = 5'd19; #0.5 check("R7 no alias", rdData, 32'hA5A5_0000 | 32'(19 * 7)); cyc();

        // R8: relock keeps contents; write in the dropping cycle still lands
        tag = "R8";
        addr = 5'd1; wrData = 32'hCAFE_0001; wrEn = 1; protDis = 0; cyc();
        wrData = 32'hBEEF_0001; cyc(); wrEn = 0; cyc();
        #0.5 check("R8 relocked", rdData, 32'hCAFE_0001); cyc();
        tag = "R5";
        addr = 5'd2; #0.5 check("R5 read while locked", rdData, 32'hA5A5_0000 | 32'(14)); cyc();
        tag = "R8";
        protDis = 1; ifClkEn = 0; cyc(); ifClkEn = 1; cyc();
        wr(5'd1, 32'h5555_0001);
        addr = 5'd1; #0.5 check("R8 clock-enable lock", rdData, 32'hCAFE_0001); cyc();

        // R6: tamper together with a write
        tag = "R6";
        unlock();
        addr = 5'd6; wrData = 32'h7777_0006; wrEn = 1; tamper = 1;
        #0.5 check("R6 during tamper", rdData, 32'h0); cyc();
        wrEn = 0; tamper = 0; cyc();
        for (int a = 0; a < 20; a++) begin addr = 5'(a); #0.5 check("R6 erased", rdData, 32'h0); cyc(); end
        wr(5'd6, 32'h8888_0006);
        addr = 5'd6; #0.5 check("R6 usable after", rdData, 32'h8888_0006); cyc();

        // mixed traffic against the model
        tag = "R4 mixed";
        for (int n = 0; n < 600; n++) begin
          addr = 5'($urandom_range(0, 23)); wrData = $urandom; wrEn = 1'($urandom);
          rtcClkEn = ($urandom_range(0, 7) != 0);
          protDis = ($urandom_range(0, 9) != 0);
          ifClkEn = ($urandom_range(0, 19) != 0);
          tamper = ($urandom_range(0, 59) == 0);
          cyc();
        end
        tamper = 0; cyc(2);
      end
      begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule